// File: doc/BRIEF.md
# Four-Digit Decimal Stopwatch

The block is a stopwatch clocked at 100 Hz. Four decimal digit counters are chained so that each one advances only when every digit below it holds 9 and the watch is running. The digits show, from lowest to highest, hundredths of a second, tenths, seconds and tens of seconds. Each digit feeds its own seven-segment pattern onto the output bus. The bus is read directly by the display drivers, so there is no scanning.

Two active-low push buttons, start and stop, drive a three-state controller. The controller is sampled on every clock edge. In the clear state every digit is held at zero. In the run state the lowest digit is enabled. In the hold state the digits keep their value so that the shown time is frozen. Debouncing and the 100 Hz clock come from outside the block.

Top module: `stopwatch_core`

## Requirements
- R1: When both buttons are low at a clock edge, the controller enters the clear state (code 00). At the following edge every digit becomes 0, and all digits stay 0 for as long as the clear state lasts.
- R2: When start alone is low at an edge, the controller enters the run state (code 01). On each later edge in that state the hundredths digit advances by one.
- R3: A digit advances only on an edge where the watch is running and every lower digit holds 9. On such an edge a digit that holds 9 wraps to 0, and the next digit up advances in that same edge.
- R4: From 99.99 s the next running edge shows 00.00. The carry out of the top digit has no other effect.
- R5: When stop alone is low at an edge, the controller enters the hold state (code 10). If the watch was running, that edge still counts once. After that the digits do not change.
- R6: When start is pressed in the hold state, counting resumes from the held value without clearing it. The edge on which start is sampled does not advance the count.
- R7: With both buttons high the controller keeps its current state: a running watch keeps counting and a held value stays held. The unused code 11 returns to the clear state.
- R8: Each digit is shown as a 7-bit pattern with bit 0 = segment a and bit 6 = segment g. The patterns for 0 to 9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 27, 7F and 6F (hex). Any other value gives 00.
- R9: Pressing stop alone while in the clear state enters the hold state and shows 00.00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 100 Hz counting clock |
| start_n | input | 1 | Start button, active low, debounced |
| stop_n | input | 1 | Stop button, active low, debounced |
| seg | output | 28 | Segment patterns: bits 6:0 hundredths, 13:7 tenths, 20:14 seconds, 27:21 tens of seconds |

## Verification
A wrong controller state shows on the bus one edge after the button sample that caused it. If the watch fails to freeze, the next edge moves the hundredths pattern. If it fails to clear, a non-zero pattern remains two edges after both buttons are pressed. A broken carry link stays hidden until the lower digits reach 9. Because of this, the stimulus deliberately crosses every 9-to-0 boundary, up to the full rollover at 99.99 s, and checks the upper patterns at the exact edge of each carry.

// File: rtl/sw_pkg.sv
package sw_pkg;

   localparam int SEG_W = 7;

   typedef enum logic [1:0] {
      ST_CLEAR = 2'b00,
      ST_RUN   = 2'b01,
      ST_HOLD  = 2'b10
   } sw_state_e;

   // bit 0 = segment a ... bit 6 = segment g
   function automatic logic [SEG_W-1:0] seg_of(input logic [3:0] v);
      logic [SEG_W-1:0] p;
      case (v)
         4'd0: p = 7'h3F;
         4'd1: p = 7'h06;
         4'd2: p = 7'h5B;
         4'd3: p = 7'h4F;
         4'd4: p = 7'h66;
         4'd5: p = 7'h6D;
         4'd6: p = 7'h7D;
         4'd7: p = 7'h27;
         4'd8: p = 7'h7F;
         4'd9: p = 7'h6F;
         default: p = 7'h00;
      endcase
      return p;
   endfunction

endpackage

// File: rtl/sw_ctrl.sv
module sw_ctrl
   import sw_pkg::*;
(
   input  logic      clk,
   input  logic      start_n,
   input  logic      stop_n,
   output sw_state_e state
);

   sw_state_e state_q;
   sw_state_e state_d;
   logic [1:0] press;

   assign press = {~start_n, ~stop_n};

   always_comb begin
      case (press)
         2'b11:   state_d = ST_CLEAR;
         2'b10:   state_d = ST_RUN;
         2'b01:   state_d = ST_HOLD;
         default: begin
            case (state_q)
               ST_CLEAR, ST_RUN, ST_HOLD: state_d = state_q;
               default:                   state_d = ST_CLEAR;
            endcase
         end
      endcase
   end

   always_ff @(posedge clk) begin
      state_q <= state_d;
   end

   assign state = state_q;

endmodule

// File: rtl/sw_digit.sv
module sw_digit #(
   parameter int MAX_VAL = 9,
   parameter int W       = 4
) (
   input  logic         clk,
   input  logic         clr,
   input  logic         cin,
   output logic [W-1:0] val,
   output logic         cout
);

   localparam logic [W-1:0] TOP = W'(MAX_VAL);

   if (MAX_VAL >= (1 << W)) begin : g_bad_width
      $error("sw_digit: width too small for MAX_VAL");
   end

   logic [W-1:0] val_q;
   logic         at_top;

   assign at_top = (val_q == TOP);

   always_ff @(posedge clk) begin
      if (clr) begin
         val_q <= '0;
      end else if (cin) begin
         val_q <= at_top ? '0 : val_q + 1'b1;
      end
   end

   assign val  = val_q;
   assign cout = cin & at_top;

endmodule

// File: rtl/sw_segdec.sv
module sw_segdec
   import sw_pkg::*;
#(
   parameter int W = 4
) (
   input  logic [W-1:0]     val,
   output logic [SEG_W-1:0] seg
);

   logic [3:0] nib;

   if (W > 4) begin : g_wide
      $error("sw_segdec: decimal digit wider than four bits");
   end

   if (W == 4) begin : g_exact
      assign nib = val;
   end else begin : g_pad
      assign nib = {{(4-W){1'b0}}, val};
   end

   assign seg = seg_of(nib);

endmodule

// File: rtl/stopwatch_core.sv
module stopwatch_core
   import sw_pkg::*;
#(
   parameter int DIGIT_COUNT = 4,
   parameter int DIGIT_MAX   = 9
) (
   input  logic                         clk,
   input  logic                         start_n,
   input  logic                         stop_n,
   output logic [DIGIT_COUNT*SEG_W-1:0] seg
);

   localparam int CNT_W = (DIGIT_MAX < 2) ? 1 : $clog2(DIGIT_MAX + 1);

   if (DIGIT_COUNT < 1) begin : g_bad_count
      $error("stopwatch_core: need at least one digit");
   end
   if (DIGIT_MAX < 1 || DIGIT_MAX > 9) begin : g_bad_max
      $error("stopwatch_core: digit limit must be 1..9");
   end

   sw_state_e                            state;
   logic                                 clear_all;
   logic [DIGIT_COUNT:0]                 carry;
   logic [DIGIT_COUNT-1:0][CNT_W-1:0]    digit_val;

   sw_ctrl u_ctrl (
      .clk     (clk),
      .start_n (start_n),
      .stop_n  (stop_n),
      .state   (state)
   );

   assign clear_all = (state == ST_CLEAR);
   assign carry[0]  = (state == ST_RUN);

   for (genvar i = 0; i < DIGIT_COUNT; i++) begin : g_digit
      sw_digit #(
         .MAX_VAL (DIGIT_MAX),
         .W       (CNT_W)
      ) u_cnt (
         .clk  (clk),
         .clr  (clear_all),
         .cin  (carry[i]),
         .val  (digit_val[i]),
         .cout (carry[i+1])
      );

      sw_segdec #(
         .W (CNT_W)
      ) u_dec (
         .val (digit_val[i]),
         .seg (seg[i*SEG_W +: SEG_W])
      );
   end

endmodule

// File: rtl/stopwatch_core_chk.sv
module stopwatch_core_chk #(
   parameter int DIGIT_COUNT = 4,
   parameter int CNT_W       = 4,
   parameter int DIGIT_MAX   = 9
) (
   input logic                              clk,
   input logic                              start_n,
   input logic                              stop_n,
   input logic [1:0]                        state,
   input logic [DIGIT_COUNT-1:0][CNT_W-1:0] digit_val,
   input logic                              roll
);

   localparam logic [CNT_W-1:0] TOP = CNT_W'(DIGIT_MAX);

   logic armed = 1'b0;
   logic [DIGIT_COUNT-1:0] below_full;

   always_ff @(posedge clk) begin
      if (state == 2'b00) armed <= 1'b1;
   end

   always_comb begin
      below_full[0] = 1'b1;
      for (int k = 1; k < DIGIT_COUNT; k++) begin
         below_full[k] = below_full[k-1] & (digit_val[k-1] == TOP);
      end
   end

   assert_clear_R1: assert property (@(posedge clk) disable iff (!armed)
      (state == 2'b00) |=> (digit_val == '0));

   assert_step_R2: assert property (@(posedge clk) disable iff (!armed)
      (state == 2'b01 && digit_val[0] != TOP) |=>
      (digit_val[0] == CNT_W'($past(digit_val[0]) + 1'b1)));

   for (genvar i = 1; i < DIGIT_COUNT; i++) begin : g_chain
      assert_carry_R3: assert property (@(posedge clk) disable iff (!armed)
         (state == 2'b01 && below_full[i]) |=>
         (digit_val[i] == (($past(digit_val[i]) == TOP) ? '0 :
                           CNT_W'($past(digit_val[i]) + 1'b1))));

      assert_still_R3: assert property (@(posedge clk) disable iff (!armed)
         (state != 2'b00 && !below_full[i]) |=> $stable(digit_val[i]));
   end

   assert_wrap_R4: assert property (@(posedge clk) disable iff (!armed)
      roll |=> (digit_val == '0));

   assert_freeze_R5: assert property (@(posedge clk) disable iff (!armed)
      (state == 2'b10) |=> $stable(digit_val));

   assert_idle_R7: assert property (@(posedge clk) disable iff (!armed)
      (start_n && stop_n && state != 2'b11) |=> $stable(state));

   assert_legal_R7: assert property (@(posedge clk) disable iff (!armed)
      state != 2'b11);

endmodule

bind stopwatch_core stopwatch_core_chk #(
   .DIGIT_COUNT (DIGIT_COUNT),
   .CNT_W       (CNT_W),
   .DIGIT_MAX   (DIGIT_MAX)
) u_chk (
   .clk       (clk),
   .start_n   (start_n),
   .stop_n    (stop_n),
   .state     (state),
   .digit_val (digit_val),
   .roll      (carry[DIGIT_COUNT])
);

// File: tb/stopwatch_core_bench.sv
`timescale 1ns/1ps
module stopwatch_core_bench;

   localparam int NSTEP = 8;
   localparam int STEP_CYC [NSTEP] = '{9, 1, 89, 1, 899, 1, 8999, 1};
   localparam int STEP_EXP [NSTEP] = '{9, 10, 99, 100, 999, 1000, 9999, 0};
   localparam int STEP_REQ [NSTEP] = '{2, 3, 3, 3, 3, 3, 3, 4};

   logic        clk = 1'b0;
   logic        start_n = 1'b0;
   logic        stop_n  = 1'b0;
   logic [27:0] seg;

   int checks = 0;
   int failures = 0;
   int model = 0;
   bit done = 1'b0;

   stopwatch_core u_stopwatch_core (
      .clk     (clk),
      .start_n (start_n),
      .stop_n  (stop_n),
      .seg     (seg)
   );

   always #2 clk = ~clk;

   function automatic logic [6:0] pat(input int d);
      case (d)
         0: return 7'h3F;  1: return 7'h06;  2: return 7'h5B;
         3: return 7'h4F;  4: return 7'h66;  5: return 7'h6D;
         6: return 7'h7D;  7: return 7'h27;  8: return 7'h7F;
         9: return 7'h6F;  default: return 7'h00;
      endcase
   endfunction

   function automatic logic [27:0] expect_bus(input int v);
      return {pat((v / 1000) % 10), pat((v / 100) % 10),
              pat((v / 10) % 10), pat(v % 10)};
   endfunction

   function automatic string tag_of(input int r);
      case (r)
         2: return "R2";
         3: return "R3";
         default: return "R4";
      endcase
   endfunction

   task automatic tick(input int n);
      for (int k = 0; k < n; k++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic check_val(input string req, input int v);
      checks++;
      if (seg !== expect_bus(v)) begin
         failures++;
         $display("FAIL %s: seg=%h expected=%h (value %0d)", req, seg, expect_bus(v), v);
      end
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog: run did not end, expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      // both pressed: clear state, then digits zero (R1)
      tick(2);
      check_val("R1", 0);
      tick(3);
      check_val("R1", 0);

      // start: entering edge does not count (R2)
      start_n = 1'b1; stop_n = 1'b1;
      start_n = 1'b0;
      tick(1);
      check_val("R2", 0);
      start_n = 1'b1;   // released: keeps running (R7)
      model = 0;

      // table walk across carries and rollover (R2, R3, R4)
      for (int s = 0; s < NSTEP; s++) begin
         tick(STEP_CYC[s]);
         model = (model + STEP_CYC[s]) % 10000;
         if (model != STEP_EXP[s]) $display("bench table mismatch at %0d", s);
         check_val(tag_of(STEP_REQ[s]), STEP_EXP[s]);
      end

      // keep running with no button (R7)
      tick(37);
      check_val("R7", 37);

      // stop: that edge still counts, then frozen (R5)
      stop_n = 1'b0;
      tick(1);
      check_val("R5", 38);
      stop_n = 1'b1;
      tick(50);
      check_val("R5", 38);

      // resume without clearing (R6)
      start_n = 1'b0;
      tick(1);
      check_val("R6", 38);
      start_n = 1'b1;
      tick(5);
      check_val("R6", 43);

      // both pressed while running: one more count, then zero (R1)
      start_n = 1'b0; stop_n = 1'b0;
      tick(1);
      check_val("R1", 44);
      tick(1);
      check_val("R1", 0);
      start_n = 1'b1; stop_n = 1'b1;

      // stop from clear: hold at zero (R9)
      stop_n = 1'b0;
      tick(1);
      stop_n = 1'b1;
      tick(10);
      check_val("R9", 0);

      // every segment pattern on the lowest digit (R8)
      start_n = 1'b0;
      tick(1);
      start_n = 1'b1;
      check_val("R8", 0);
      for (int d = 1; d <= 9; d++) begin
         tick(1);
         check_val("R8", d);
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule